// File: doc/BRIEF.md
# Boost Converter Switching Timebase with External Lock

This block sets the switching period for a boost power-factor stage. After reset it runs on its own. A phase counter wraps every `period_i` system clocks. Each wrap gives a switch-off strobe, and a period-start strobe follows one clock later. Duty control downstream uses these two strobes to end and begin each gate pulse.

A level input reports that the frequency pin sits in synchronization mode. While that level is high, the block watches an external pulse train. It times the interval between successive rising edges. An interval counts as good when it lies inside the supported switching band, 21 kHz to 100 kHz. With a 50 MHz clock that is 500 to 2380 clocks. After six good intervals in a row, the block locks. While locked, each external rising edge ends the gate pulse, so the switching rate tracks the external rate. A bad interval, a quiet input for the loss timeout (108 µs, 5400 clocks), or a low mode level all drop the lock. The internal period then takes over again.

The reset input is active low and asynchronous. It is expected to be released synchronously to `clk_i`. `period_i` must be at least 2.

Top module: `pfc_sync_timebase`

## Requirements
- R1: While reset is held, and at the first sample after release, `sw_off_o`, `period_start_o` and `locked_o` are all 0.
- R2: While unlocked, `sw_off_o` pulses for one clock, once every `period_i` clocks.
- R3: `period_start_o` pulses exactly one clock after every `sw_off_o` pulse and at no other time.
- R4: With `sync_mode_i` low, external pulses never cause lock. Dropping `sync_mode_i` while locked clears `locked_o` within four clocks.
- R5: The block locks on the rising edge that completes six consecutive good intervals. The first edge after idle gives no interval, so seven edges are needed from idle. `locked_o` and the first aligned `sw_off_o` appear together, three clocks after the edge is driven at the pin.
- R6: An interval shorter than 500 clocks or longer than 2380 clocks clears lock and restarts the good-interval count. That edge then serves as the reference for the next interval.
- R7: While locked, `sw_off_o` pulses three clocks after each external rising edge, and only then. The strobe spacing follows a change of external frequency with no added pulses.
- R8: If no external rising edge arrives for 5400 clocks, `locked_o` falls in the 5403rd clock after the last edge was driven. The strobe spacing then returns to `period_i`.
- R9: When an external edge and an internal wrap fall in the same clock, one single `sw_off_o` pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| period_i | input | CNT_W (16) | Internal switching period in clocks, at least 2 |
| sync_mode_i | input | 1 | Level: frequency pin is above the sync threshold |
| sync_pulse_i | input | 1 | External sync pulse, asynchronous |
| sw_off_o | output | 1 | One-clock strobe ending the gate pulse |
| period_start_o | output | 1 | One-clock strobe starting the next gate pulse |
| locked_o | output | 1 | External timing in control |

## Verification
The internal wrap and an external edge can land in the same clock. They then compete to produce the switch-off strobe. The bench provokes this by watching an internal strobe while unlocked and driving the external train at exactly the internal period, timed so that each synchronized edge meets a wrap. It judges the result by seeing exactly one `sw_off_o` pulse, with no repeat in the following clock and a `period_start_o` right after it, both before lock and on the locking edge. Lock acquisition in that same run shows that the shared strobe also counts as a valid external edge.

// File: rtl/pfc_sync_pkg.sv
`timescale 1ns/1ps
package pfc_sync_pkg;

  // Event record produced by the interval meter each clock.
  typedef struct packed {
    logic rise;   // synchronized external rising edge while in sync mode
    logic qual;   // that edge closed an interval inside the allowed band
    logic lost;   // no edge for the full loss timeout
  } gap_evt_t;

  // Clocks per switching period for a given frequency.
  function automatic int ticks_for_hz(input int clk_hz, input int f_hz);
    return clk_hz / f_hz;
  endfunction

  // Clocks in a time span given in nanoseconds (kept in 32-bit range).
  function automatic int ticks_for_ns(input int clk_hz, input int span_ns);
    return ((clk_hz / 1_000_000) * span_ns) / 1000;
  endfunction

endpackage

// File: rtl/pfc_sync_in.sv
`timescale 1ns/1ps
module pfc_sync_in #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  input  logic mode_i,
  output logic rise_o,
  output logic mode_o
);

  // One extra stage on the pulse path holds the previous value for edge detection.
  logic [STAGES:0]   pulse_sh_q;
  logic [STAGES-1:0] mode_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_sh_q <= '0;
      mode_sh_q  <= '0;
    end else begin
      pulse_sh_q <= {pulse_sh_q[STAGES-1:0], pulse_i};
      mode_sh_q  <= {mode_sh_q[STAGES-2:0], mode_i};
    end
  end

  assign rise_o = pulse_sh_q[STAGES-1] & ~pulse_sh_q[STAGES];
  assign mode_o = mode_sh_q[STAGES-1];

endmodule

// File: rtl/pfc_gap_meter.sv
`timescale 1ns/1ps
module pfc_gap_meter
  import pfc_sync_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int MIN_PER  = 500,
  parameter int MAX_PER  = 2380,
  parameter int LOSS_CYC = 5400
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     mode_i,
  input  logic     rise_i,
  output gap_evt_t evt_o
);

  localparam logic [CNT_W-1:0] MinC  = CNT_W'(MIN_PER);
  localparam logic [CNT_W-1:0] MaxC  = CNT_W'(MAX_PER);
  localparam logic [CNT_W-1:0] LossC = CNT_W'(LOSS_CYC);

  // gap_q == 0 means no reference edge; otherwise clocks since the last edge.
  logic [CNT_W-1:0] gap_q, gap_n;
  logic             lost;

  always_comb begin
    gap_n = gap_q;
    lost  = 1'b0;
    if (!mode_i) begin
      gap_n = '0;
    end else if (rise_i) begin
      gap_n = CNT_W'(1);
    end else if (gap_q == LossC) begin
      gap_n = '0;
      lost  = 1'b1;
    end else if (gap_q != '0) begin
      gap_n = gap_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gap_q <= '0;
    else         gap_q <= gap_n;
  end

  assign evt_o.rise = rise_i & mode_i;
  assign evt_o.qual = rise_i & mode_i & (gap_q >= MinC) & (gap_q <= MaxC);
  assign evt_o.lost = lost;

endmodule

// File: rtl/pfc_lock_ctrl.sv
`timescale 1ns/1ps
module pfc_lock_ctrl
  import pfc_sync_pkg::*;
#(
  parameter int LOCK_COUNT = 6
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     mode_i,
  input  gap_evt_t evt_i,
  output logic     lock_q_o,
  output logic     lock_n_o
);

  localparam int CW = $clog2(LOCK_COUNT + 1);

  logic [CW-1:0] good_q, good_n;
  logic          lock_q, lock_n;

  always_comb begin
    good_n = good_q;
    lock_n = lock_q;
    if (!mode_i || evt_i.lost) begin
      good_n = '0;
      lock_n = 1'b0;
    end else if (evt_i.rise) begin
      if (!evt_i.qual) begin
        good_n = '0;
        lock_n = 1'b0;
      end else if (!lock_q) begin
        if (good_q == CW'(LOCK_COUNT - 1)) begin
          good_n = '0;
          lock_n = 1'b1;
        end else begin
          good_n = good_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      good_q <= '0;
      lock_q <= 1'b0;
    end else begin
      good_q <= good_n;
      lock_q <= lock_n;
    end
  end

  assign lock_q_o = lock_q;
  assign lock_n_o = lock_n;

endmodule

// File: rtl/pfc_sync_timebase.sv
`timescale 1ns/1ps
module pfc_sync_timebase
  import pfc_sync_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int F_MIN_HZ    = 21_000,
  parameter int F_MAX_HZ    = 100_000,
  parameter int LOSS_NS     = 108_000,
  parameter int LOCK_COUNT  = 6,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic             sync_mode_i,
  input  logic             sync_pulse_i,
  output logic             sw_off_o,
  output logic             period_start_o,
  output logic             locked_o
);

  localparam int MinPer  = ticks_for_hz(CLK_HZ, F_MAX_HZ);
  localparam int MaxPer  = ticks_for_hz(CLK_HZ, F_MIN_HZ);
  localparam int LossCyc = ticks_for_ns(CLK_HZ, LOSS_NS);

  logic     mode_s, rise_s, ext_rise;
  gap_evt_t evt;
  logic     lock_q, lock_n;

  pfc_sync_in #(.STAGES(SYNC_STAGES)) u_in (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pulse_i(sync_pulse_i),
    .mode_i (sync_mode_i),
    .rise_o (rise_s),
    .mode_o (mode_s)
  );

  pfc_gap_meter #(
    .CNT_W   (CNT_W),
    .MIN_PER (MinPer),
    .MAX_PER (MaxPer),
    .LOSS_CYC(LossCyc)
  ) u_meter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mode_i(mode_s),
    .rise_i(rise_s),
    .evt_o (evt)
  );

  pfc_lock_ctrl #(.LOCK_COUNT(LOCK_COUNT)) u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_s),
    .evt_i   (evt),
    .lock_q_o(lock_q),
    .lock_n_o(lock_n)
  );

  assign ext_rise = evt.rise;

  // Phase counter: wraps on the internal period, or on the external edge once locked.
  logic [CNT_W-1:0] ph_q, ph_n;
  logic             wrap;
  logic             off_q, start_q;

  always_comb begin
    if (lock_n) wrap = ext_rise;
    else        wrap = (ph_q >= (period_i - 1'b1));
    if (wrap)             ph_n = '0;
    else if (&ph_q)       ph_n = ph_q;
    else                  ph_n = ph_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= '0;
      off_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      ph_q    <= ph_n;
      off_q   <= wrap;
      start_q <= off_q;
    end
  end

  assign sw_off_o       = off_q;
  assign period_start_o = start_q;
  assign locked_o       = lock_q;

endmodule

// File: rtl/pfc_sync_timebase_chk.sv
`timescale 1ns/1ps
module pfc_sync_timebase_chk #(
  parameter int LOSS_CYC = 5400,
  parameter int CNT_W    = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic mode_s,
  input logic ext_rise,
  input logic sw_off_o,
  input logic period_start_o,
  input logic locked_o
);

  // Clocks since the last accepted external edge, saturating.
  logic [CNT_W-1:0] quiet_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       quiet_q <= '0;
    else if (ext_rise) quiet_q <= '0;
    else if (~&quiet_q) quiet_q <= quiet_q + 1'b1;
  end

  assert_start_after_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_off_o |=> period_start_o);

  assert_start_only_after_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_start_o |-> $past(sw_off_o));

  assert_no_lock_without_mode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_s |=> !locked_o);

  assert_lock_on_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(ext_rise));

  assert_edge_gives_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rise |=> (!locked_o || sw_off_o));

  assert_locked_off_from_edge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_off_o && locked_o) |-> $past(ext_rise));

  assert_loss_unlocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet_q >= CNT_W'(LOSS_CYC)) |-> !locked_o);

  assert_single_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_off_o |=> !sw_off_o);

endmodule

bind pfc_sync_timebase pfc_sync_timebase_chk #(
  .LOSS_CYC(LossCyc),
  .CNT_W   (CNT_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mode_s        (mode_s),
  .ext_rise      (ext_rise),
  .sw_off_o      (sw_off_o),
  .period_start_o(period_start_o),
  .locked_o      (locked_o)
);

// File: tb/test_pfc_sync_timebase.sv
`timescale 1ns/1ps
module test_pfc_sync_timebase;

  localparam int DEF_PER = 769;
  localparam int LOSS    = 5400;

  logic        clk;
  logic        rst_n;
  logic [15:0] period;
  logic        sync_mode;
  logic        sync_pulse;
  logic        sw_off, period_start, locked;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  pfc_sync_timebase i_pfc_sync_timebase (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .period_i      (period),
    .sync_mode_i   (sync_mode),
    .sync_pulse_i  (sync_pulse),
    .sw_off_o      (sw_off),
    .period_start_o(period_start),
    .locked_o      (locked)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge; drives one external pulse and consumes exactly gap negedges.
  task automatic pulse(input int gap, input bit chk_lock, input logic exp_lock,
                       input bit chk_off, input string req);
    sync_pulse = 1'b1;
    repeat (3) @(negedge clk);
    if (chk_lock) check(locked === exp_lock, req, locked, exp_lock);
    if (chk_off)  check(sw_off === 1'b1, req, sw_off, 1);
    @(negedge clk);
    if (chk_off) begin
      check(sw_off === 1'b0, "R9", sw_off, 0);
      check(period_start === 1'b1, "R3", period_start, 1);
    end
    repeat (6) @(negedge clk);
    sync_pulse = 1'b0;
    repeat (gap - 10) @(negedge clk);
  endtask

  task automatic wait_off();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (sw_off) break;
    end
  endtask

  task automatic spacing(input int exp, input string req);
    int cnt;
    wait_off();
    cnt = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      cnt++;
      if (sw_off) break;
    end
    check(cnt == exp, req, cnt, exp);
  endtask

  task automatic reenter_sync();
    @(negedge clk);
    sync_mode = 1'b0;
    repeat (5) @(negedge clk);
    sync_mode = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; period = DEF_PER; sync_mode = 1'b0; sync_pulse = 1'b0;
    repeat (4) @(negedge clk);
    check(sw_off === 1'b0 && period_start === 1'b0 && locked === 1'b0, "R1",
          {sw_off, period_start, locked}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(sw_off === 1'b0 && period_start === 1'b0 && locked === 1'b0, "R1",
          {sw_off, period_start, locked}, 0);
  endtask

  task automatic t_free_run();
    spacing(DEF_PER, "R2");
    @(negedge clk);
    check(period_start === 1'b1, "R3", period_start, 1);
    @(negedge clk);
    check(period_start === 1'b0, "R3", period_start, 0);
    period = 16'd600;
    spacing(600, "R2");
    spacing(600, "R2");
    period = DEF_PER;
    spacing(DEF_PER, "R2");
  endtask

  task automatic t_no_mode();
    @(negedge clk);
    for (int i = 0; i < 9; i++) pulse(1000, 1'b1, 1'b0, 1'b0, "R4");
  endtask

  task automatic t_lock_follow_loss();
    reenter_sync();
    for (int i = 0; i < 6; i++) pulse(1000, 1'b1, 1'b0, 1'b0, "R5");
    pulse(1000, 1'b1, 1'b1, 1'b1, "R5");
    pulse(1000, 1'b1, 1'b1, 1'b1, "R7");
    pulse(600,  1'b1, 1'b1, 1'b1, "R7");
    pulse(600,  1'b1, 1'b1, 1'b1, "R7");
    pulse(600,  1'b1, 1'b1, 1'b1, "R7");
    // last edge, then silence
    sync_pulse = 1'b1;
    repeat (3) @(negedge clk);
    check(sw_off === 1'b1, "R7", sw_off, 1);
    repeat (7) @(negedge clk);
    sync_pulse = 1'b0;
    repeat (LOSS + 2 - 10) @(negedge clk);
    check(locked === 1'b1, "R8", locked, 1);
    @(negedge clk);
    check(locked === 1'b0, "R8", locked, 0);
    spacing(DEF_PER, "R8");
  endtask

  task automatic t_reject();
    reenter_sync();
    for (int i = 0; i < 6; i++) pulse(1000, 1'b0, 1'b0, 1'b0, "R5");
    pulse(400, 1'b1, 1'b1, 1'b1, "R5");
    pulse(1000, 1'b1, 1'b0, 1'b0, "R6");             // 400-clock interval rejected
    for (int i = 0; i < 5; i++) pulse(1000, 1'b1, 1'b0, 1'b0, "R6");
    pulse(3000, 1'b1, 1'b1, 1'b1, "R6");             // count restarted from reject edge
    pulse(1000, 1'b1, 1'b0, 1'b0, "R6");             // 3000-clock interval rejected
    for (int i = 0; i < 5; i++) pulse(1000, 1'b0, 1'b0, 1'b0, "R6");
    pulse(1000, 1'b1, 1'b1, 1'b1, "R6");
    sync_mode = 1'b0;
    repeat (4) @(negedge clk);
    check(locked === 1'b0, "R4", locked, 0);
  endtask

  task automatic t_coincide();
    reenter_sync();
    wait_off();
    repeat (DEF_PER - 3) @(negedge clk);
    for (int i = 0; i < 6; i++) pulse(DEF_PER, 1'b1, 1'b0, 1'b1, "R9");
    pulse(DEF_PER, 1'b1, 1'b1, 1'b1, "R9");
  endtask

  initial begin
    t_reset();
    t_free_run();
    t_no_mode();
    t_lock_follow_loss();
    t_reject();
    t_coincide();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule